// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of the chip's clock sources drives the system clock. Software writes a 3-bit source code. The block checks whether that source is ready. A ready target is taken over on the next clock edge. A target that is not ready raises a switch-fail status bit, and the request is kept as pending. The pending request completes by itself on the first edge at which the target reports ready. No further write is needed, and the fail bit stays set.

Each oscillator reports its own stable flag. The PLL is the exception: its flag is produced here by a settling counter. The counter restarts whenever the PLL or the whole system is powered down. It counts source-clock ticks up to one of two settle lengths, chosen by a select input. The glitch-free multiplexing of the clocks themselves is done elsewhere. This block only issues the selection that the clock mux follows.

Top module: `clk_switch_ctrl`

## Requirements
- R1: After reset, `cur_sel_o` equals the parameter `RST_SEL` (default 3'b111), `switch_fail_o` is 0 and `pll_stable_o` is 0.
- R2: A write (`sel_wr_i`=1) of a code whose source is ready updates `cur_sel_o` to that code and clears `switch_fail_o`. Both changes appear after the same clock edge that samples the write.
- R3: A write of a code whose source is not ready sets `switch_fail_o` to 1 and leaves `cur_sel_o` unchanged.
- R4: A pending switch completes on the first edge at which its target is ready: `cur_sel_o` takes the target code and `switch_fail_o` stays 1.
- R5: `switch_fail_o` changes only on an accepted select write. Otherwise it holds its value.
- R6: A write of the unused code 3'b110 is ignored. It changes neither the selection, the fail bit nor any pending target.
- R7: A write accepted while a switch is pending replaces the pending target and sets the fail bit again from the new target's readiness.
- R8: Code mapping to readiness uses `osc_stable_i` bits [0]=high-speed crystal, [1]=low-speed crystal, [2]=low-speed RC, [3]=high-speed RC. Codes 000 and 001 use bits [0] and [1]. Code 011 uses bit [2]. Codes 100 and 111 (RC/2) use bit [3]. Codes 010 and 101 (PLL/2) use `pll_stable_o`.
- R9: With `pll_pd_i`=0 and `sys_pd_i`=0, `pll_stable_o` rises after exactly 6144 cycles with `pll_tick_i`=1 when `pll_long_i`=0, or after exactly 12288 such cycles when `pll_long_i`=1. The count starts at the release of power-down, and cycles without a tick are not counted.
- R10: `pll_pd_i`=1 or `sys_pd_i`=1 clears `pll_stable_o` after the next edge and restarts the settle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_wr_i | input | 1 | Select write strobe |
| sel_data_i | input | 3 | Requested source code |
| osc_stable_i | input | 4 | Enabled-and-stable flags of the four oscillators |
| pll_pd_i | input | 1 | PLL power-down |
| sys_pd_i | input | 1 | System power-down |
| pll_long_i | input | 1 | Settle length select: 0 short, 1 long |
| pll_tick_i | input | 1 | One PLL source-clock cycle elapsed |
| cur_sel_o | output | 3 | Source currently selected |
| switch_fail_o | output | 1 | Last accepted write targeted a source that was not ready |
| pll_stable_o | output | 1 | PLL settled and powered |

## Verification
Every result is due one edge after its stimulus. A write or a readiness change shows on `cur_sel_o` and `switch_fail_o` after the edge that samples it. Power-down and the final settle tick show on `pll_stable_o` after one edge. A PLL-based target becomes ready one edge after `pll_stable_o` rises, so such a switch completes two edges after the last tick. The bench drives inputs at the falling edge. Its model advances by exactly one edge per step, and it compares at the next falling edge, so each check lands on the cycle where that result is due.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [2:0] {
    SRC_HXT       = 3'd0,
    SRC_LXT       = 3'd1,
    SRC_PLL       = 3'd2,
    SRC_LIRC      = 3'd3,
    SRC_HIRC      = 3'd4,
    SRC_PLL_HALF  = 3'd5,
    SRC_RSVD      = 3'd6,
    SRC_HIRC_HALF = 3'd7
  } clk_src_e;

  localparam int unsigned N_OSC    = 4;
  localparam int unsigned OSC_HXT  = 0;
  localparam int unsigned OSC_LXT  = 1;
  localparam int unsigned OSC_LIRC = 2;
  localparam int unsigned OSC_HIRC = 3;
  localparam int unsigned SEL_W    = 3;
endpackage

// File: rtl/clksw_src_ready.sv
module clksw_src_ready
  import clksw_pkg::*;
(
  input  logic [SEL_W-1:0] code_i,
  input  logic [N_OSC-1:0] osc_stable_i,
  input  logic             pll_stable_i,
  output logic             ready_o
);
  always_comb begin
    unique case (code_i)
      SRC_HXT:                 ready_o = osc_stable_i[OSC_HXT];
      SRC_LXT:                 ready_o = osc_stable_i[OSC_LXT];
      SRC_LIRC:                ready_o = osc_stable_i[OSC_LIRC];
      SRC_HIRC, SRC_HIRC_HALF: ready_o = osc_stable_i[OSC_HIRC];
      SRC_PLL, SRC_PLL_HALF:   ready_o = pll_stable_i;
      default:                 ready_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/clksw_pll_settle.sv
module clksw_pll_settle #(
  parameter int unsigned SHORT_CNT = 6144,
  parameter int unsigned LONG_CNT  = 12288
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic sys_pd_i,
  input  logic tick_i,
  input  logic long_i,
  output logic stable_o
);
  localparam int unsigned CW = $clog2(LONG_CNT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_nxt;
  logic [CW:0]   limit;
  logic          stable_q;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign limit   = long_i ? (CW+1)'(LONG_CNT) : (CW+1)'(SHORT_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (pd_i || sys_pd_i) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (tick_i && !stable_q) begin
      cnt_q <= cnt_nxt[CW-1:0];
      if (cnt_nxt >= limit) stable_q <= 1'b1;
    end
  end

  assign stable_o = stable_q;
endmodule

// File: rtl/clksw_switch_fsm.sv
module clksw_switch_fsm
  import clksw_pkg::*;
#(
  parameter logic [SEL_W-1:0] RST_SEL = 3'b111
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] code_i,
  input  logic             code_ready_i,
  input  logic             tgt_ready_i,
  output logic [SEL_W-1:0] cur_sel_o,
  output logic [SEL_W-1:0] tgt_o,
  output logic             pending_o,
  output logic             fail_o
);
  logic [SEL_W-1:0] cur_q, tgt_q;
  logic             pend_q, fail_q;
  logic             wr_ok;

  assign wr_ok = wr_i && (code_i != SRC_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= RST_SEL;
      tgt_q  <= RST_SEL;
      pend_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (wr_ok) begin
      tgt_q  <= code_i;
      fail_q <= !code_ready_i;
      pend_q <= !code_ready_i;
      if (code_ready_i) cur_q <= code_i;
    end else if (pend_q && tgt_ready_i) begin
      cur_q  <= tgt_q;
      pend_q <= 1'b0;
    end
  end

  assign cur_sel_o = cur_q;
  assign tgt_o     = tgt_q;
  assign pending_o = pend_q;
  assign fail_o    = fail_q;
endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
  import clksw_pkg::*;
#(
  parameter int unsigned      SHORT_CNT = 6144,
  parameter int unsigned      LONG_CNT  = 12288,
  parameter logic [SEL_W-1:0] RST_SEL   = 3'b111
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_data_i,
  input  logic [N_OSC-1:0] osc_stable_i,
  input  logic             pll_pd_i,
  input  logic             sys_pd_i,
  input  logic             pll_long_i,
  input  logic             pll_tick_i,
  output logic [SEL_W-1:0] cur_sel_o,
  output logic             switch_fail_o,
  output logic             pll_stable_o
);
  logic             pll_ok;
  logic             code_rdy;
  logic             tgt_rdy;
  logic             pend;
  logic [SEL_W-1:0] tgt;

  clksw_pll_settle #(
    .SHORT_CNT(SHORT_CNT),
    .LONG_CNT (LONG_CNT)
  ) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pd_i    (pll_pd_i),
    .sys_pd_i(sys_pd_i),
    .tick_i  (pll_tick_i),
    .long_i  (pll_long_i),
    .stable_o(pll_ok)
  );

  clksw_src_ready u_rdy_req (
    .code_i      (sel_data_i),
    .osc_stable_i(osc_stable_i),
    .pll_stable_i(pll_ok),
    .ready_o     (code_rdy)
  );

  clksw_src_ready u_rdy_tgt (
    .code_i      (tgt),
    .osc_stable_i(osc_stable_i),
    .pll_stable_i(pll_ok),
    .ready_o     (tgt_rdy)
  );

  clksw_switch_fsm #(
    .RST_SEL(RST_SEL)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (sel_wr_i),
    .code_i      (sel_data_i),
    .code_ready_i(code_rdy),
    .tgt_ready_i (tgt_rdy),
    .cur_sel_o   (cur_sel_o),
    .tgt_o       (tgt),
    .pending_o   (pend),
    .fail_o      (switch_fail_o)
  );

  assign pll_stable_o = pll_ok;
endmodule

// File: rtl/clk_switch_ctrl_chk.sv
module clk_switch_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_wr_i,
  input logic [2:0] sel_data_i,
  input logic       pll_pd_i,
  input logic       sys_pd_i,
  input logic [2:0] cur_sel_o,
  input logic       switch_fail_o,
  input logic       pll_stable_o,
  input logic       pend,
  input logic       code_rdy
);
  logic wr_ok;
  assign wr_ok = sel_wr_i && (sel_data_i != 3'b110);

  AST_READY_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && code_rdy) |=> (cur_sel_o == $past(sel_data_i)) && !switch_fail_o); // R2

  AST_UNREADY_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && !code_rdy) |=> switch_fail_o && $stable(cur_sel_o)); // R3

  AST_FAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok |=> $stable(switch_fail_o)); // R5

  AST_RSVD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && sel_data_i == 3'b110 && !pend) |=> $stable(cur_sel_o)); // R6

  AST_PLL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_pd_i || sys_pd_i) |=> !pll_stable_o); // R10

  AST_PLL_RISE_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_stable_o) |-> !$past(pll_pd_i) && !$past(sys_pd_i)); // R9

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      AST_SEL_LEGAL: assert (cur_sel_o != 3'b110); // R8
    end
  end
endmodule

bind clk_switch_ctrl clk_switch_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_wr_i     (sel_wr_i),
  .sel_data_i   (sel_data_i),
  .pll_pd_i     (pll_pd_i),
  .sys_pd_i     (sys_pd_i),
  .cur_sel_o    (cur_sel_o),
  .switch_fail_o(switch_fail_o),
  .pll_stable_o (pll_stable_o),
  .pend         (pend),
  .code_rdy     (code_rdy)
);

// File: tb/clk_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_switch_ctrl_tb_top;
  localparam int unsigned SHORT_CNT = 6144;
  localparam int unsigned LONG_CNT  = 12288;
  localparam logic [2:0]  RST_SEL   = 3'b111;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_wr = 1'b0;
  logic [2:0] sel_data = '0;
  logic [3:0] osc = 4'b1111;
  logic       pll_pd = 1'b1;
  logic       sys_pd = 1'b0;
  logic       pll_long = 1'b0;
  logic       pll_tick = 1'b0;
  logic [2:0] cur_sel;
  logic       sw_fail;
  logic       pll_st;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [2:0] m_cur, m_tgt;
  bit         m_pend, m_fail, m_pll;
  int         m_cnt;

  always #2.5 clk = ~clk;

  clk_switch_ctrl #(
    .SHORT_CNT(SHORT_CNT),
    .LONG_CNT (LONG_CNT),
    .RST_SEL  (RST_SEL)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sel_wr_i     (sel_wr),
    .sel_data_i   (sel_data),
    .osc_stable_i (osc),
    .pll_pd_i     (pll_pd),
    .sys_pd_i     (sys_pd),
    .pll_long_i   (pll_long),
    .pll_tick_i   (pll_tick),
    .cur_sel_o    (cur_sel),
    .switch_fail_o(sw_fail),
    .pll_stable_o (pll_st)
  );

  function automatic bit m_ready(logic [2:0] c, logic [3:0] o, bit p);
    case (c)
      3'd0: return o[0];
      3'd1: return o[1];
      3'd3: return o[2];
      3'd4, 3'd7: return o[3];
      3'd2, 3'd5: return p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // drive at falling edge, advance model one edge, compare at next falling edge
  task automatic step(bit wr, logic [2:0] code, logic [3:0] o, bit pd, bit spd,
                      bit lng, bit tk, string tag);
    bit rdy_code, rdy_tgt, pll_now;
    int lim;
    sel_wr = wr; sel_data = code; osc = o;
    pll_pd = pd; sys_pd = spd; pll_long = lng; pll_tick = tk;
    pll_now   = m_pll;
    rdy_code  = m_ready(code, o, pll_now);
    rdy_tgt   = m_ready(m_tgt, o, pll_now);
    if (wr && code != 3'b110) begin
      m_tgt  = code;
      m_fail = !rdy_code;
      m_pend = !rdy_code;
      if (rdy_code) m_cur = code;
    end else if (m_pend && rdy_tgt) begin
      m_cur  = m_tgt;
      m_pend = 0;
    end
    lim = lng ? LONG_CNT : SHORT_CNT;
    if (pd || spd) begin
      m_cnt = 0; m_pll = 0;
    end else if (tk && !m_pll) begin
      m_cnt++;
      if (m_cnt >= lim) m_pll = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "cur_sel", int'(cur_sel), int'(m_cur));
    chk(tag, "fail", int'(sw_fail), int'(m_fail));
    chk(tag, "pll_stable", int'(pll_st), int'(m_pll));
  endtask

  task automatic idle(int n, logic [3:0] o, bit pd, bit lng, bit tk, string tag);
    for (int i = 0; i < n; i++) step(0, 3'd0, o, pd, 0, lng, tk, tag);
  endtask

  initial begin
    int unsigned seed;
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit tk;
    logic [3:0] ro;
    bit rpd;
    void'($urandom(32'hC10C_5EED));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cur_sel", int'(cur_sel), int'(RST_SEL));
    chk("R1", "fail", int'(sw_fail), 0);
    chk("R1", "pll_stable", int'(pll_st), 0);
    rst_n = 1'b1;
    m_cur = RST_SEL; m_tgt = RST_SEL; m_pend = 0; m_fail = 0; m_pll = 0; m_cnt = 0;

    step(1, 3'd0, 4'b1111, 1, 0, 0, 0, "R2");   // ready crystal
    step(1, 3'd1, 4'b1101, 1, 0, 0, 0, "R3");   // low crystal not ready
    idle(4, 4'b1101, 1, 0, 0, "R5");
    step(0, 3'd0, 4'b1111, 1, 0, 0, 0, "R4");   // becomes ready -> completes
    step(1, 3'd6, 4'b1111, 1, 0, 0, 0, "R6");
    step(1, 3'd3, 4'b1011, 1, 0, 0, 0, "R7");   // LIRC unready -> pending
    step(1, 3'd6, 4'b1111, 1, 0, 0, 0, "R6");   // reserved keeps pending target
    step(1, 3'd3, 4'b1011, 1, 0, 0, 0, "R7");   // re-pend
    step(1, 3'd0, 4'b1011, 1, 0, 0, 0, "R7");   // replace with ready target
    idle(2, 4'b1111, 1, 0, 0, "R7");            // old target ready: no switch
    step(1, 3'd7, 4'b0111, 1, 0, 0, 0, "R8");   // HIRC/2 unready
    step(1, 3'd7, 4'b1111, 1, 0, 0, 0, "R8");
    step(1, 3'd4, 4'b1111, 1, 0, 0, 0, "R8");
    step(1, 3'd5, 4'b1111, 1, 0, 0, 0, "R8");   // PLL/2 while PLL down
    // R9 short settle with continuous ticks
    idle(SHORT_CNT - 1, 4'b1111, 0, 0, 1, "R9");
    chk("R9", "pll_not_yet", int'(pll_st), 0);
    idle(1, 4'b1111, 0, 0, 1, "R9");
    chk("R9", "pll_short_done", int'(pll_st), 1);
    idle(1, 4'b1111, 0, 0, 1, "R4");            // pending PLL/2 completes
    chk("R4", "cur_pll_half", int'(cur_sel), 5);
    step(1, 3'd2, 4'b1111, 0, 0, 0, 1, "R8");
    step(0, 3'd0, 4'b1111, 1, 0, 0, 1, "R10");  // PLL power-down
    idle(2, 4'b1111, 0, 0, 1, "R10");
    step(0, 3'd0, 4'b1111, 0, 1, 0, 1, "R10");  // system power-down restart
    // R9 long settle, tick every other cycle
    for (int i = 0; i < 2 * LONG_CNT + 4; i++)
      step(0, 3'd0, 4'b1111, 0, 0, 1, i[0], "R9");
    chk("R9", "pll_long_done", int'(pll_st), 1);
    // constrained random mix
    rpd = 0;
    for (int i = 0; i < 4000; i++) begin
      ro = 4'($urandom);
      tk = ($urandom % 4) != 0;
      if (($urandom % 64) == 0) rpd = !rpd;
      step(($urandom % 3) == 0, 3'($urandom), ro, rpd, ($urandom % 128) == 0,
           ($urandom % 2) == 1, tk, "R7");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule